// File: doc/BRIEF.md
# Burst Column Address Generator

This block produces the column address for every beat of a synchronous DRAM burst. A command strobe loads a start column, a read/write flag and the current mode settings. From the next clock on, the block outputs one column address per cycle, together with a beat-valid flag and a flag that marks the final beat. The mode settings are the burst length code, the ordering (sequential or interleaved) and the single-write mode bit.

Fixed-length bursts of 2, 4 or 8 beats stay inside the aligned block that holds the start column, and only the low column bits change. Sequential ordering counts upward modulo the length. Interleaved ordering XORs the beat index into the low start bits. A full-page burst steps through all columns of the row in sequential order and wraps from the top column back to zero. It never ends on its own. A terminate input, driven for a burst stop or a precharge, stops beat generation. A new command issued during a burst replaces the running burst. Command spacing, bank state and data-path latency belong to the surrounding controller.

The beats cannot be held back, because the memory consumes one column per clock. For that reason the interface has no ready signal, and every pin is a plain control or status signal.

Top module: `burst_col_gen`

## Requirements
- R1: After reset, and until the first accepted command, `beat_valid` and `beat_last` are 0. `beat_last` is never 1 while `beat_valid` is 0.
- R2: When `cmd_valid` is sampled high, the first beat appears in the next cycle with `col_addr` equal to `start_col`. Length codes 0, 1, 2 and 3 give exactly 1, 2, 4 and 8 consecutive valid beats. `beat_last` is 1 on the final beat only.
- R3: With `order_ilv`=0 and a fixed length N, beat k carries `start_col` with its low log2(N) bits replaced by (low bits + k) mod N. The upper bits are unchanged.
- R4: With `order_ilv`=1 and a fixed length N, beat k carries `start_col` with its low log2(N) bits XORed with k.
- R5: A length code with bit 2 set selects a full-page burst. Beat k carries (`start_col` + k) mod 512, so the address wraps from 511 to 0. The burst continues until terminated or replaced, and `beat_last` stays 0 throughout.
- R6: A full-page burst uses sequential order even when `order_ilv`=1.
- R7: A write (`cmd_write`=1) accepted while `wr_single`=1 produces exactly one beat, with `beat_last`=1, whatever the length code. A read accepted while `wr_single`=1 uses the programmed length.
- R8: When `term` is sampled high with `cmd_valid` low, `beat_valid` is 0 from the next cycle on.
- R9: A command accepted during a burst ends the running burst, and the new burst starts from its own start column in the next cycle. If `cmd_valid` and `term` are high in the same cycle, the command takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Read or write command registered this cycle |
| cmd_write | input | 1 | 1 for write, 0 for read |
| start_col | input | 9 | Starting column of the burst |
| len_code | input | 3 | Burst length: 0=1, 1=2, 2=4, 3=8, bit 2 set = full page |
| order_ilv | input | 1 | 0 sequential, 1 interleaved |
| wr_single | input | 1 | Single-write mode: writes use one beat |
| term | input | 1 | Burst stop or precharge registered this cycle |
| beat_valid | output | 1 | A column address is presented this cycle |
| col_addr | output | 9 | Column address of the current beat |
| beat_last | output | 1 | Current beat is the final beat of a fixed-length burst |

## Verification
The assertions assume that `cmd_valid`, `term` and the mode inputs are known and sampled only on the rising edge. They also assume that mode inputs matter only in the cycle `cmd_valid` is high. The checker therefore tracks the full-page state itself from the command cycle, and it does not rely on the mode pins staying steady. The stimulus changes inputs only on the falling edge, holds `cmd_valid` and `term` for single cycles, and sweeps every length code and both orders. It also issues commands back to back, combines a command with a terminate in the same cycle, and runs a full-page burst across the 511-to-0 wrap.

// File: rtl/bcg_pkg.sv
package bcg_pkg;
  // length code field layout: bit 2 selects full page, bits 1:0 give log2 of the fixed length
  localparam int unsigned LEN_CODE_W = 3;
  localparam int unsigned LEN_FULL_BIT = 2;

  typedef enum logic {
    ORD_SEQ = 1'b0,
    ORD_ILV = 1'b1
  } order_e;
endpackage

// File: rtl/bcg_mode_dec.sv
module bcg_mode_dec
  import bcg_pkg::*;
#(
  parameter int unsigned COL_W = 9
) (
  input  logic [LEN_CODE_W-1:0] len_code,
  input  logic                  is_write,
  input  logic                  wr_single,
  input  logic                  ilv_req,
  output logic [COL_W-1:0]      mask,
  output logic [COL_W-1:0]      lenm1,
  output logic                  full,
  output order_e                order
);
  logic single_beat;
  logic [1:0] shift;

  always_comb begin
    single_beat = is_write && wr_single;
    shift = single_beat ? 2'd0 : len_code[1:0];
    full  = !single_beat && len_code[LEN_FULL_BIT];
    if (full) begin
      mask  = '1;
      lenm1 = '1;
      order = ORD_SEQ;
    end else begin
      lenm1 = ~({COL_W{1'b1}} << shift);
      mask  = lenm1;
      order = ilv_req ? ORD_ILV : ORD_SEQ;
    end
  end
endmodule

// File: rtl/bcg_beat_ctr.sv
module bcg_beat_ctr #(
  parameter int unsigned COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             stop,
  input  logic             full,
  input  logic [COL_W-1:0] lenm1,
  output logic             active,
  output logic [COL_W-1:0] cnt,
  output logic             last
);
  assign last = active && !full && (cnt == lenm1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (load) begin
      active <= 1'b1;
      cnt    <= '0;
    end else if (stop) begin
      active <= 1'b0;
    end else if (active) begin
      if (last) active <= 1'b0;
      else      cnt    <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/bcg_addr_map.sv
module bcg_addr_map
  import bcg_pkg::*;
#(
  parameter int unsigned COL_W = 9
) (
  input  logic [COL_W-1:0] start,
  input  logic [COL_W-1:0] cnt,
  input  logic [COL_W-1:0] mask,
  input  order_e           order,
  output logic [COL_W-1:0] col
);
  logic [COL_W-1:0] low_seq;
  logic [COL_W-1:0] low_ilv;

  always_comb begin
    low_seq = (start + cnt) & mask;
    low_ilv = (start ^ cnt) & mask;
    col = (start & ~mask) | ((order == ORD_ILV) ? low_ilv : low_seq);
  end
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import bcg_pkg::*;
#(
  parameter int unsigned COL_W = 9
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmd_valid,
  input  logic                  cmd_write,
  input  logic [COL_W-1:0]      start_col,
  input  logic [LEN_CODE_W-1:0] len_code,
  input  logic                  order_ilv,
  input  logic                  wr_single,
  input  logic                  term,
  output logic                  beat_valid,
  output logic [COL_W-1:0]      col_addr,
  output logic                  beat_last
);
  logic [COL_W-1:0] dec_mask, dec_lenm1;
  logic             dec_full;
  order_e           dec_order;

  logic [COL_W-1:0] start_q, mask_q, lenm1_q;
  logic             full_q;
  order_e           order_q;
  logic [COL_W-1:0] cnt;

  bcg_mode_dec #(.COL_W(COL_W)) u_dec (
    .len_code (len_code),
    .is_write (cmd_write),
    .wr_single(wr_single),
    .ilv_req  (order_ilv),
    .mask     (dec_mask),
    .lenm1    (dec_lenm1),
    .full     (dec_full),
    .order    (dec_order)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q <= '0;
      mask_q  <= '0;
      lenm1_q <= '0;
      full_q  <= 1'b0;
      order_q <= ORD_SEQ;
    end else if (cmd_valid) begin
      start_q <= start_col;
      mask_q  <= dec_mask;
      lenm1_q <= dec_lenm1;
      full_q  <= dec_full;
      order_q <= dec_order;
    end
  end

  bcg_beat_ctr #(.COL_W(COL_W)) u_ctr (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (cmd_valid),
    .stop  (term),
    .full  (full_q),
    .lenm1 (lenm1_q),
    .active(beat_valid),
    .cnt   (cnt),
    .last  (beat_last)
  );

  bcg_addr_map #(.COL_W(COL_W)) u_map (
    .start(start_q),
    .cnt  (cnt),
    .mask (mask_q),
    .order(order_q),
    .col  (col_addr)
  );
endmodule

// File: rtl/bcg_checker.sv
module bcg_checker #(
  parameter int unsigned COL_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic             cmd_write,
  input logic [COL_W-1:0] start_col,
  input logic [2:0]       len_code,
  input logic             wr_single,
  input logic             term,
  input logic             beat_valid,
  input logic [COL_W-1:0] col_addr,
  input logic             beat_last
);
  logic full_run;

  always_ff @(posedge clk) begin
    if (!rst_n) full_run <= 1'b0;
    else if (cmd_valid) full_run <= len_code[2] && !(cmd_write && wr_single);
  end

  // R1
  a_r1_last_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    beat_last |-> beat_valid);

  // R2, R9
  a_r9_cmd_starts_burst: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> (beat_valid && col_addr == $past(start_col)));

  // R5
  a_r5_full_no_last: assert property (@(posedge clk) disable iff (!rst_n)
    (full_run && beat_valid) |-> !beat_last);

  // R5, R6
  a_r5_full_step: assert property (@(posedge clk) disable iff (!rst_n)
    (full_run && beat_valid && $past(beat_valid) && !$past(cmd_valid) && $past(rst_n))
      |-> col_addr == COL_W'($past(col_addr) + 1'b1));

  // R7
  a_r7_single_write: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_write && wr_single) |=> beat_last);

  // R8
  a_r8_term_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (term && !cmd_valid) |=> !beat_valid);
endmodule

bind burst_col_gen bcg_checker #(.COL_W(COL_W)) u_bcg_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_write (cmd_write),
  .start_col (start_col),
  .len_code  (len_code),
  .wr_single (wr_single),
  .term      (term),
  .beat_valid(beat_valid),
  .col_addr  (col_addr),
  .beat_last (beat_last)
);

// File: tb/burst_col_gen_test.sv
module burst_col_gen_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0, cmd_write = 1'b0, order_ilv = 1'b0, wr_single = 1'b0, term = 1'b0;
  logic [8:0] start_col = '0;
  logic [2:0] len_code = '0;
  logic       beat_valid, beat_last;
  logic [8:0] col_addr;

  int checks = 0, fails = 0;
  bit done = 0;

  // behavioural reference state
  bit m_active = 0;
  int m_start = 0, m_k = 0, m_len = 1;  // m_len 0 means full page
  bit m_ilv = 0;

  always #2 clk = ~clk;

  burst_col_gen uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
    .start_col(start_col), .len_code(len_code), .order_ilv(order_ilv),
    .wr_single(wr_single), .term(term), .beat_valid(beat_valid),
    .col_addr(col_addr), .beat_last(beat_last)
  );

  task automatic model_update();
    if (!rst_n) m_active = 0;
    else if (cmd_valid) begin
      m_active = 1; m_k = 0; m_start = int'(start_col);
      if (cmd_write && wr_single) m_len = 1;
      else if (len_code[2]) m_len = 0;
      else m_len = 1 << len_code[1:0];
      m_ilv = order_ilv && (m_len != 0);
    end else if (term) m_active = 0;
    else if (m_active) begin
      if (m_len != 0 && m_k == m_len - 1) m_active = 0;
      else m_k = m_k + 1;
    end
  endtask

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    int exp_col, low, base;
    check(tag, "beat_valid", int'(beat_valid), int'(m_active));
    if (m_active) begin
      if (m_len == 0) exp_col = (m_start + m_k) % 512;
      else begin
        base = m_start - (m_start % m_len);
        low  = m_start % m_len;
        exp_col = base + (m_ilv ? (low ^ m_k) : ((low + m_k) % m_len));
      end
      check(tag, "col_addr", int'(col_addr), exp_col);
      check(tag, "beat_last", int'(beat_last), int'(m_len != 0 && m_k == m_len - 1));
    end else
      check(tag, "beat_last", int'(beat_last), 0);
  endtask

  task automatic tick(string tag);
    @(posedge clk);
    model_update();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle(string tag, int n);
    for (int i = 0; i < n; i++) tick(tag);
  endtask

  task automatic issue(string tag, int col, int code, bit ilv, bit wr, bit single, bit t);
    cmd_valid = 1; start_col = 9'(col); len_code = 3'(code);
    order_ilv = ilv; cmd_write = wr; wr_single = single; term = t;
    tick(tag);
    cmd_valid = 0; term = 0;
  endtask

  task automatic stop_now(string tag);
    term = 1;
    tick(tag);
    term = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog all actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    idle("R1", 3);
    rst_n = 1;
    idle("R1", 3);
    // R2 / R3: sequential fixed lengths
    for (int c = 0; c < 4; c++) begin
      issue("R2", 9'h0D5, c, 0, 0, 0, 0);
      idle("R3", 10);
    end
    issue("R3", 9'h1FF, 3, 0, 0, 0, 0);
    idle("R3", 9);
    // R4: interleaved
    for (int c = 1; c < 4; c++) begin
      issue("R4", 9'h013, c, 1, 0, 0, 0);
      idle("R4", 9);
    end
    issue("R4", 9'h1A6, 3, 1, 1, 0, 0);
    idle("R4", 9);
    // R5: full page across the wrap, then terminate (R8)
    issue("R5", 9'h1FC, 4, 0, 0, 0, 0);
    idle("R5", 12);
    stop_now("R8");
    idle("R8", 3);
    // R6: full page with interleave requested
    issue("R6", 9'h0FD, 7, 1, 1, 0, 0);
    idle("R6", 8);
    stop_now("R8");
    idle("R8", 2);
    // R7: single-write mode
    issue("R7", 9'h044, 3, 0, 1, 1, 0);
    idle("R7", 4);
    issue("R7", 9'h044, 4, 0, 1, 1, 0);
    idle("R7", 4);
    issue("R7", 9'h046, 2, 1, 0, 1, 0);
    idle("R7", 6);
    issue("R7", 9'h046, 2, 0, 1, 0, 0);
    idle("R7", 6);
    // R8: terminate a fixed burst mid-way
    issue("R8", 9'h120, 3, 0, 0, 0, 0);
    idle("R8", 2);
    stop_now("R8");
    idle("R8", 4);
    // R9: restart during burst, and command beating terminate
    issue("R9", 9'h0A3, 3, 0, 0, 0, 0);
    idle("R9", 3);
    issue("R9", 9'h157, 2, 1, 0, 0, 0);
    issue("R9", 9'h032, 3, 0, 0, 0, 0);
    idle("R9", 2);
    issue("R9", 9'h1F0, 4, 0, 0, 0, 1);
    idle("R9", 20);
    issue("R9", 9'h009, 1, 0, 0, 0, 1);
    idle("R9", 4);
    idle("R1", 2);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule